// File: doc/BRIEF.md
# Power Management Status and Control Register

This block is one 8-bit status and control register inside a microcontroller's power management logic. Two of its bits are sticky event flags: a low-voltage warning flag and a flag that records a wake-up from the partial power-down stop mode (stop2). Each flag has its own write-1 acknowledge bit. The warning flag can only be cleared once the warning condition has gone away.

The remaining bits configure the part. Two trip-point select bits choose the voltage thresholds of the detect comparator and the warning comparator. Only a power-on reset clears these two bits. Two write-once bits enable the power-down modes and choose between full power down (stop1) and partial power down (stop2). Software reads the register over a simple bus. The stop-mode sequencer uses the decoded enables `stop1_en` and `stop2_en`.

A synchronous active-high reset applies the reset state. A cause code presented with it tells the block whether the reset is a power-on reset.

Top module: `pmsc_reg`

## Requirements
- R1: Read data shows, from bit 7 down to bit 0: warning flag, 0, detect trip select, warning trip select, stop2-recovery flag, 0, power-down enable, partial-power-down select. The two acknowledge positions (bits 6 and 2) always read 0. Read data is all zeros while `reg_rd` is low.
- R2: The warning flag is set on the clock edge at which `lvw_level` is 1. It stays set after `lvw_level` returns to 0.
- R3: A write with bit 6 set clears the warning flag only if `lvw_level` is 0 in that cycle. A write with bit 6 set while `lvw_level` is 1 leaves the flag set. A write with bit 6 clear has no effect on the flag.
- R4: A `stop2_exit` pulse sets the stop2-recovery flag. A write with bit 2 set clears it regardless of any other input. A write with bit 2 clear has no effect on it.
- R5: When a set event and a clearing acknowledge for the same flag fall in the same cycle, the flag ends up set.
- R6: Every write loads bits 5 and 4 into the detect and warning trip selects. These selects also drive `lvd_trip_hi` and `lvw_trip_hi`.
- R7: A reset with `rst_cause` = 2 (power-on) clears both trip selects. A reset with cause 0 (other) or 1 (low-voltage detect) leaves them unchanged.
- R8: After any reset, the first write loads bit 1 into the power-down enable. Later writes leave the enable unchanged until the next reset.
- R9: After any reset, the first write loads bit 0 into the partial-power-down select. Later writes leave the select unchanged until the next reset.
- R10: `stop1_en` is enable AND NOT select. `stop2_en` is enable AND select.
- R11: After reset, the stop2-recovery flag, the enable and the select are 0. The warning flag equals the `lvw_level` seen during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_cause | input | 2 | Cause of the reset: 0 other, 1 low-voltage detect, 2 power-on |
| reg_rd | input | 1 | Read strobe; enables `reg_rdata` |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| lvw_level | input | 1 | Live low-voltage warning level from the comparator |
| stop2_exit | input | 1 | One-cycle pulse when the part leaves stop2 |
| lvd_trip_hi | output | 1 | Detect trip select |
| lvw_trip_hi | output | 1 | Warning trip select |
| pd_enable | output | 1 | Power-down modes enabled |
| ppd_select | output | 1 | Partial power down selected |
| stop1_en | output | 1 | Full power-down stop mode enabled |
| stop2_en | output | 1 | Partial power-down stop mode enabled |

## Verification
Every stored bit comes from a single register stage. A write, a level, a pulse or a reset applied in the cycle before an edge therefore shows on `reg_rdata` and on the control outputs right after that edge. The read data and the decoded enables then follow that state combinationally in the same cycle. The bench changes all inputs 1 ns after a rising edge and checks outputs 1 ns after the next rising edge. Each check therefore sees exactly one edge's worth of update.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;
    localparam int REG_W      = 8;
    localparam int POS_WFLAG  = 7;
    localparam int POS_WACK   = 6;
    localparam int POS_DSEL   = 5;
    localparam int POS_WSEL   = 4;
    localparam int POS_PFLAG  = 3;
    localparam int POS_PACK   = 2;
    localparam int POS_PDEN   = 1;
    localparam int POS_PSEL   = 0;
    localparam int N_FLAGS    = 2;
    localparam int N_ONCE     = 2;
    localparam int TRIP_W     = 2;

    typedef enum logic [1:0] {
        CAUSE_OTHER = 2'd0,
        CAUSE_LVD   = 2'd1,
        CAUSE_POR   = 2'd2
    } rst_cause_e;
endpackage

// File: rtl/pmsc_flag.sv
module pmsc_flag #(
    parameter bit ACK_NEEDS_IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_val_i,
    input  logic set_i,
    input  logic ack_i,
    input  logic cond_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = ack_i && (!ACK_NEEDS_IDLE || !cond_i);
        if (rst) begin
            st_d.flag = rst_val_i;
        end else if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_ok) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R2 R4 R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R3 R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !ack_i) |=> $stable(flag_o));

    generate
        if (ACK_NEEDS_IDLE) begin : g_cond
            // R3
            flag_ack_blocked_chk: assert property (@(posedge clk) disable iff (rst)
                (ack_i && cond_i && flag_o) |=> flag_o);
        end
    endgenerate
endmodule

// File: rtl/pmsc_once.sv
module pmsc_once #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] val_o
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         locked;
    } once_st_t;

    once_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val    = '0;
            st_d.locked = 1'b0;
        end else if (wr_i && !st_q.locked) begin
            st_d.val    = wdata_i;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign val_o = st_q.val;

    // R8 R9
    once_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.locked && wr_i) |=> $stable(val_o));

    // R8 R9
    once_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(val_o));
endmodule

// File: rtl/pmsc_trip.sv
module pmsc_trip
    import pmsc_pkg::*;
#(
    parameter int W = TRIP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         por_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] sel_o
);
    typedef struct packed {
        logic [W-1:0] sel;
    } trip_st_t;

    trip_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            if (por_i) begin
                st_d.sel = '0;
            end
        end else if (wr_i) begin
            st_d.sel = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o = st_q.sel;

    // R6
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(sel_o));

    // R6
    trip_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (sel_o == $past(wdata_i)));
endmodule

// File: rtl/pmsc_reg.sv
module pmsc_reg
    import pmsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       rst_cause,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             lvw_level,
    input  logic             stop2_exit,
    output logic             lvd_trip_hi,
    output logic             lvw_trip_hi,
    output logic             pd_enable,
    output logic             ppd_select,
    output logic             stop1_en,
    output logic             stop2_en
);
    localparam bit [N_FLAGS-1:0] ACK_COND = 2'b01;
    localparam int FLAG_POS [N_FLAGS] = '{POS_WFLAG, POS_PFLAG};
    localparam int ACK_POS  [N_FLAGS] = '{POS_WACK,  POS_PACK};
    localparam int ONCE_POS [N_ONCE]  = '{POS_PDEN,  POS_PSEL};

    logic [N_FLAGS-1:0] flag_set, flag_ack, flag_rst_val, flag_q;
    logic [N_ONCE-1:0]  once_q;
    logic [TRIP_W-1:0]  trip_q;
    logic               por_cause;

    assign por_cause       = (rst_cause == CAUSE_POR);
    assign flag_set[0]     = lvw_level;
    assign flag_set[1]     = stop2_exit;
    assign flag_rst_val[0] = lvw_level;
    assign flag_rst_val[1] = 1'b0;

    generate
        for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
            assign flag_ack[g] = reg_wr && reg_wdata[ACK_POS[g]];
            pmsc_flag #(.ACK_NEEDS_IDLE(ACK_COND[g])) u_flag (
                .clk       (clk),
                .rst       (rst),
                .rst_val_i (flag_rst_val[g]),
                .set_i     (flag_set[g]),
                .ack_i     (flag_ack[g]),
                .cond_i    (lvw_level),
                .flag_o    (flag_q[g])
            );
        end
        for (genvar g = 0; g < N_ONCE; g++) begin : g_once
            pmsc_once #(.W(1)) u_once (
                .clk     (clk),
                .rst     (rst),
                .wr_i    (reg_wr),
                .wdata_i (reg_wdata[ONCE_POS[g]]),
                .val_o   (once_q[g])
            );
        end
    endgenerate

    pmsc_trip #(.W(TRIP_W)) u_trip (
        .clk     (clk),
        .rst     (rst),
        .por_i   (por_cause),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata[POS_DSEL:POS_WSEL]),
        .sel_o   (trip_q)
    );

    logic [REG_W-1:0] status;

    always_comb begin
        status            = '0;
        status[POS_WFLAG] = flag_q[0];
        status[POS_PFLAG] = flag_q[1];
        status[POS_DSEL]  = trip_q[1];
        status[POS_WSEL]  = trip_q[0];
        status[POS_PDEN]  = once_q[0];
        status[POS_PSEL]  = once_q[1];
        reg_rdata         = reg_rd ? status : '0;
    end

    assign lvd_trip_hi = trip_q[1];
    assign lvw_trip_hi = trip_q[0];
    assign pd_enable   = once_q[0];
    assign ppd_select  = once_q[1];
    assign stop1_en    = once_q[0] && !once_q[1];
    assign stop2_en    = once_q[0] &&  once_q[1];

    // R3
    warn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_ack[0] && !lvw_level) |=> !flag_q[0]);

    // R4
    ppd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_ack[1] && !stop2_exit) |=> !flag_q[1]);

    // R10
    stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stop1_en && stop2_en));
endmodule

// File: tb/pmsc_reg_bench.sv
module pmsc_reg_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rst_cause = 2'd2;
    logic       reg_rd = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lvw_level = 1'b0;
    logic       stop2_exit = 1'b0;
    logic       lvd_trip_hi, lvw_trip_hi, pd_enable, ppd_select, stop1_en, stop2_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmsc_reg u_pmsc_reg (
        .clk(clk), .rst(rst), .rst_cause(rst_cause),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lvw_level(lvw_level), .stop2_exit(stop2_exit),
        .lvd_trip_hi(lvd_trip_hi), .lvw_trip_hi(lvw_trip_hi),
        .pd_enable(pd_enable), .ppd_select(ppd_select),
        .stop1_en(stop1_en), .stop2_en(stop2_en)
    );

    task automatic step();
        @(posedge clk);
        #1ns;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] cause, logic lvl);
        rst = 1'b1; rst_cause = cause; lvw_level = lvl;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic t_reset_state();
        do_reset(2'd2, 1'b0);
        check("R11 por reset rdata", reg_rdata, 8'h00);
        check("R11 reset outputs",
              {2'b00, lvd_trip_hi, lvw_trip_hi, pd_enable, ppd_select, stop1_en, stop2_en}, 8'h00);
        do_reset(2'd0, 1'b1);
        lvw_level = 1'b0;
        check("R11 warn flag from level in reset", reg_rdata, 8'h80);
    endtask

    task automatic t_warning();
        do_reset(2'd2, 1'b0);
        lvw_level = 1'b1; step();
        check("R2 warn flag set", reg_rdata, 8'h80);
        lvw_level = 1'b0; step();
        check("R2 warn flag sticky", reg_rdata, 8'h80);
        lvw_level = 1'b1; wr(8'h40);
        check("R3 ack blocked while warning present (R5)", reg_rdata, 8'h80);
        lvw_level = 1'b0; wr(8'h00);
        check("R3 write 0 to ack no effect", reg_rdata, 8'h80);
        wr(8'h40);
        check("R3 ack clears when warning absent", reg_rdata, 8'h00);
    endtask

    task automatic t_ppd();
        do_reset(2'd2, 1'b0);
        stop2_exit = 1'b1; step(); stop2_exit = 1'b0;
        check("R4 stop2 flag set", reg_rdata, 8'h08);
        step();
        check("R4 stop2 flag sticky", reg_rdata, 8'h08);
        wr(8'h00);
        check("R4 write 0 to ack no effect", reg_rdata, 8'h08);
        wr(8'h04);
        check("R4 ack clears", reg_rdata, 8'h00);
        stop2_exit = 1'b1; wr(8'h04); stop2_exit = 1'b0;
        check("R5 set wins over ack", reg_rdata, 8'h08);
        lvw_level = 1'b1; step(); lvw_level = 1'b0;
        wr(8'h04);
        check("R4 ack clears unconditionally", reg_rdata, 8'h80);
    endtask

    task automatic t_trip();
        do_reset(2'd2, 1'b0);
        wr(8'h30);
        check("R6 trip bits loaded", reg_rdata, 8'h30);
        check("R6 trip outputs", {6'd0, lvd_trip_hi, lvw_trip_hi}, 8'h03);
        wr(8'h10);
        check("R6 trip rewritable", reg_rdata, 8'h10);
        wr(8'h20);
        do_reset(2'd0, 1'b0);
        check("R7 other reset keeps trip", reg_rdata, 8'h20);
        do_reset(2'd1, 1'b0);
        check("R7 lvd reset keeps trip", reg_rdata, 8'h20);
        do_reset(2'd2, 1'b0);
        check("R7 por reset clears trip", reg_rdata, 8'h00);
    endtask

    task automatic t_once();
        do_reset(2'd2, 1'b0);
        wr(8'h03);
        check("R8 R9 first write loads", reg_rdata, 8'h03);
        check("R10 stop2_en", {6'd0, stop1_en, stop2_en}, 8'h01);
        wr(8'h00);
        check("R8 R9 later write ignored", reg_rdata, 8'h03);
        do_reset(2'd0, 1'b0);
        check("R11 once bits cleared by reset", reg_rdata, 8'h00);
        wr(8'h02);
        check("R8 enable only", reg_rdata, 8'h02);
        check("R10 stop1_en", {6'd0, stop1_en, stop2_en}, 8'h02);
        wr(8'h01);
        check("R9 select locked", {6'd0, pd_enable, ppd_select}, 8'h02);
        do_reset(2'd1, 1'b0);
        wr(8'h01);
        check("R10 select without enable", {6'd0, stop1_en, stop2_en}, 8'h00);
    endtask

    task automatic t_read();
        do_reset(2'd2, 1'b0);
        wr(8'hFF);
        check("R1 ack bits read 0", reg_rdata, 8'h33);
        reg_rd = 1'b0; #1ns;
        check("R1 rdata 0 without read", reg_rdata, 8'h00);
        reg_rd = 1'b1; #1ns;
        check("R1 rdata back", reg_rdata, 8'h33);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_warning();
        t_ppd();
        t_trip();
        t_once();
        t_read();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule